// File: doc/BRIEF.md
# Dual-Section Registered Bus Transceiver

This block joins two buses, called A and B, through a bidirectional transceiver of 16 data bits. The bits form two independent 8-bit sections, and each section has its own clocks, selects and enables. In each direction a section holds a storage register that loads on the rising edge of its own capture clock. A per-direction select then sends either the live data from the opposite bus or the stored value to the output. An output enable decides whether that side drives its bus at all.

Each bus appears as separate input, output and output-enable ports, so the surrounding logic resolves the bus and no tristate nets are needed. A capture register loads on every clock edge, whatever the selects and enables are set to. When a section is set to live mode in both directions with both sides enabled, each output returns the value that its own bus carries. A bus with no other driver therefore keeps its last value. An optional synchronous clear gives the registers a known value, because they have no reset.

Top module: `dual_regbus_xcvr`

## Requirements
- R1: The sections are independent. The clocks, selects, enables and bus data of one section never change the outputs or the stored values of another section. Section s uses data bits [8s+7:8s] and control bit s.
- R2: On a rising edge of `cap_ab_clk[s]`, the A-to-B register of section s loads that section's `a_in` bits. On a rising edge of `cap_ba_clk[s]`, the B-to-A register loads its `b_in` bits. Between edges, each register holds its value.
- R3: A register captures on its clock edge whatever the values of `sel_ab`, `sel_ba`, `drv_b_en` and `drv_a_en_n` at that edge.
- R4: When `sel_ab[s]`=0, the B output of section s carries live `a_in` data. When `sel_ab[s]`=1, it carries the A-to-B register. `sel_ba[s]` makes the same choice for the A output, between live `b_in` and the B-to-A register.
- R5: `b_oe[s]` equals `drv_b_en[s]`, which is active-high. `a_oe[s]` equals the inverse of `drv_a_en_n[s]`, which is active-low.
- R6: While a side of a section is disabled, its output data bits are all zero.
- R7: With `HAS_CLEAR`=1, a capture edge taken while `sync_clr`=1 loads zero into that register instead of the bus data.
- R8: When both selects of a section are 0 and both sides are enabled, `b_out` equals `a_in` and `a_out` equals `b_in`. A resolved bus with no external driver then keeps its value over any number of cycles.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| cap_ab_clk | input | 2 | Per-section capture clock for the A-to-B register |
| cap_ba_clk | input | 2 | Per-section capture clock for the B-to-A register |
| sync_clr | input | 1 | Synchronous clear, applied at capture edges |
| sel_ab | input | 2 | Source of the B output per section: 0 live, 1 stored |
| sel_ba | input | 2 | Source of the A output per section: 0 live, 1 stored |
| drv_b_en | input | 2 | Active-high enable for driving bus B |
| drv_a_en_n | input | 2 | Active-low enable for driving bus A |
| a_in | input | 16 | Value seen on bus A |
| b_in | input | 16 | Value seen on bus B |
| a_out | output | 16 | Data driven onto bus A |
| a_oe | output | 2 | Per-section drive enable for bus A (0 means high impedance) |
| b_out | output | 16 | Data driven onto bus B |
| b_oe | output | 2 | Per-section drive enable for bus B (0 means high impedance) |

## Verification
The assertions are sampled on the capture clock edges and assume that `sync_clr` is a level held steady around those edges. They also assume that bus data and controls do not change at the same instant as a capture edge. The stimulus therefore changes inputs only while the capture clocks are low, then raises and lowers a clock, and only after that samples the outputs. For the loopback hold case, the bench resolves each bus itself: the external value wins while the external driver is on, and otherwise the transceiver's own output wins. It recomputes the buses one step at a time, so no combinational loop forms across the design's ports.

// File: rtl/xcvr_pkg.sv
package xcvr_pkg;
   typedef enum logic {
      SRC_LIVE   = 1'b0,
      SRC_STORED = 1'b1
   } src_sel_e;
endpackage

// File: rtl/capture_reg.sv
module capture_reg #(
   parameter int W         = 8,
   parameter bit HAS_CLEAR = 1'b1
) (
   input  logic         clk,
   input  logic         clr,
   input  logic [W-1:0] d,
   output logic [W-1:0] q
);
   if (W < 1) begin : g_bad_w
      $error("capture_reg: W must be positive");
   end

   if (HAS_CLEAR) begin : g_clr
      always_ff @(posedge clk) begin
         if (clr) q <= '0;
         else     q <= d;
      end

      // R7: a clearing edge leaves zero behind
      p_clear_zero_r7: assert property (@(posedge clk) clr |=> (q == '0));
      // R2: a plain edge leaves the sampled data behind
      p_capture_r2: assert property (@(posedge clk) disable iff (clr)
                                     !clr |=> (q == $past(d)));
   end else begin : g_noclr
      logic unused_clr;
      assign unused_clr = clr;
      always_ff @(posedge clk) q <= d;

      // R2
      p_capture_noclr_r2: assert property (@(posedge clk) 1'b1 |=> (q == $past(d)));
   end
endmodule

// File: rtl/path_mux.sv
module path_mux
   import xcvr_pkg::*;
#(
   parameter int W = 8
) (
   input  src_sel_e     sel,
   input  logic         enable,
   input  logic [W-1:0] live,
   input  logic [W-1:0] stored,
   output logic [W-1:0] dout,
   output logic         oe
);
   always_comb begin
      dout = '0;
      if (enable) dout = (sel == SRC_STORED) ? stored : live;
   end
   assign oe = enable;
endmodule

// File: rtl/xcvr_section.sv
module xcvr_section
   import xcvr_pkg::*;
#(
   parameter int W         = 8,
   parameter bit HAS_CLEAR = 1'b1
) (
   input  logic         clk_ab,
   input  logic         clk_ba,
   input  logic         clr,
   input  logic         sel_ab,
   input  logic         sel_ba,
   input  logic         en_b,
   input  logic         en_a_n,
   input  logic [W-1:0] a_in,
   input  logic [W-1:0] b_in,
   output logic [W-1:0] a_out,
   output logic         a_oe,
   output logic [W-1:0] b_out,
   output logic         b_oe
);
   logic [W-1:0] held_ab;
   logic [W-1:0] held_ba;
   logic         clr_eff;

   assign clr_eff = HAS_CLEAR ? clr : 1'b0;

   capture_reg #(.W(W), .HAS_CLEAR(HAS_CLEAR)) u_reg_ab (
      .clk(clk_ab), .clr(clr), .d(a_in), .q(held_ab));
   capture_reg #(.W(W), .HAS_CLEAR(HAS_CLEAR)) u_reg_ba (
      .clk(clk_ba), .clr(clr), .d(b_in), .q(held_ba));

   path_mux #(.W(W)) u_mux_b (
      .sel(src_sel_e'(sel_ab)), .enable(en_b),
      .live(a_in), .stored(held_ab), .dout(b_out), .oe(b_oe));
   path_mux #(.W(W)) u_mux_a (
      .sel(src_sel_e'(sel_ba)), .enable(!en_a_n),
      .live(b_in), .stored(held_ba), .dout(a_out), .oe(a_oe));

   // R6: a disabled B side is quiet
   p_b_quiet_r6: assert property (@(posedge clk_ab) disable iff (clr_eff)
      !en_b |-> (b_out == '0 && !b_oe));
   // R5: active-low enable on the A side
   p_a_polarity_r5: assert property (@(posedge clk_ba) disable iff (clr_eff)
      en_a_n |-> (!a_oe && a_out == '0));
   // R4: stored path follows the register across edges
   p_b_stored_r4: assert property (@(posedge clk_ab) disable iff (clr_eff)
      (en_b && sel_ab) |=> (!(en_b && sel_ab) || b_out == $past(a_in)));
   // R8: loopback returns each bus onto the other
   p_loop_r8: assert property (@(posedge clk_ab) disable iff (clr_eff)
      (!sel_ab && !sel_ba && en_b && !en_a_n) |-> (b_out == a_in && a_out == b_in));
endmodule

// File: rtl/dual_regbus_xcvr.sv
module dual_regbus_xcvr #(
   parameter int NUM_SECTIONS = 2,
   parameter int SECTION_W    = 8,
   parameter bit HAS_CLEAR    = 1'b1
) (
   input  logic [NUM_SECTIONS-1:0]           cap_ab_clk,
   input  logic [NUM_SECTIONS-1:0]           cap_ba_clk,
   input  logic                              sync_clr,
   input  logic [NUM_SECTIONS-1:0]           sel_ab,
   input  logic [NUM_SECTIONS-1:0]           sel_ba,
   input  logic [NUM_SECTIONS-1:0]           drv_b_en,
   input  logic [NUM_SECTIONS-1:0]           drv_a_en_n,
   input  logic [NUM_SECTIONS*SECTION_W-1:0] a_in,
   input  logic [NUM_SECTIONS*SECTION_W-1:0] b_in,
   output logic [NUM_SECTIONS*SECTION_W-1:0] a_out,
   output logic [NUM_SECTIONS-1:0]           a_oe,
   output logic [NUM_SECTIONS*SECTION_W-1:0] b_out,
   output logic [NUM_SECTIONS-1:0]           b_oe
);
   localparam int TOTAL_W = NUM_SECTIONS * SECTION_W;

   if (NUM_SECTIONS < 1) begin : g_bad_n
      $error("dual_regbus_xcvr: NUM_SECTIONS must be positive");
   end
   if (SECTION_W < 1 || TOTAL_W > 1024) begin : g_bad_w
      $error("dual_regbus_xcvr: SECTION_W out of range");
   end

   for (genvar s = 0; s < NUM_SECTIONS; s++) begin : g_sec
      xcvr_section #(.W(SECTION_W), .HAS_CLEAR(HAS_CLEAR)) u_sec (
         .clk_ab (cap_ab_clk[s]),
         .clk_ba (cap_ba_clk[s]),
         .clr    (sync_clr),
         .sel_ab (sel_ab[s]),
         .sel_ba (sel_ba[s]),
         .en_b   (drv_b_en[s]),
         .en_a_n (drv_a_en_n[s]),
         .a_in   (a_in[s*SECTION_W +: SECTION_W]),
         .b_in   (b_in[s*SECTION_W +: SECTION_W]),
         .a_out  (a_out[s*SECTION_W +: SECTION_W]),
         .a_oe   (a_oe[s]),
         .b_out  (b_out[s*SECTION_W +: SECTION_W]),
         .b_oe   (b_oe[s]));
   end
endmodule

// File: tb/dual_regbus_xcvr_bench.sv
`timescale 1ns/1ps
module dual_regbus_xcvr_bench;
   logic        clk = 1'b0;
   always #4 clk = ~clk;

   logic [1:0]  cap_ab_clk = '0, cap_ba_clk = '0;
   logic        sync_clr = 1'b0;
   logic [1:0]  sel_ab = '0, sel_ba = '0, drv_b_en = '0, drv_a_en_n = '1;
   logic [15:0] a_in = '0, b_in = '0;
   logic [15:0] a_out, b_out;
   logic [1:0]  a_oe, b_oe;

   int n_chk = 0, n_bad = 0;
   bit done = 1'b0;

   dual_regbus_xcvr u_dual_regbus_xcvr (
      .cap_ab_clk(cap_ab_clk), .cap_ba_clk(cap_ba_clk), .sync_clr(sync_clr),
      .sel_ab(sel_ab), .sel_ba(sel_ba), .drv_b_en(drv_b_en), .drv_a_en_n(drv_a_en_n),
      .a_in(a_in), .b_in(b_in), .a_out(a_out), .a_oe(a_oe), .b_out(b_out), .b_oe(b_oe));

   typedef struct packed {
      logic [7:0] a, b;
      logic sab, sba, enb, enan, cab, cba;
      logic [7:0] ea, eb;
      logic eaoe, eboe;
   } vec_t;

   // section 0 sequence; register contents carry from row to row
   localparam vec_t VEC [7] = '{
      '{8'h3C, 8'hA5, 1'b0,1'b0,1'b1,1'b0,1'b0,1'b0, 8'hA5, 8'h3C, 1'b1,1'b1},
      '{8'h5A, 8'hC3, 1'b1,1'b1,1'b1,1'b0,1'b1,1'b1, 8'hC3, 8'h5A, 1'b1,1'b1},
      '{8'h11, 8'h22, 1'b1,1'b1,1'b1,1'b0,1'b0,1'b0, 8'hC3, 8'h5A, 1'b1,1'b1},
      '{8'h77, 8'h88, 1'b0,1'b1,1'b0,1'b1,1'b1,1'b0, 8'h00, 8'h00, 1'b0,1'b0},
      '{8'h99, 8'h66, 1'b1,1'b1,1'b1,1'b0,1'b0,1'b0, 8'hC3, 8'h77, 1'b1,1'b1},
      '{8'hF0, 8'h0F, 1'b1,1'b0,1'b1,1'b1,1'b0,1'b1, 8'h00, 8'h77, 1'b0,1'b1},
      '{8'h00, 8'h00, 1'b0,1'b1,1'b0,1'b0,1'b0,1'b0, 8'h0F, 8'h00, 1'b1,1'b0}
   };

   task automatic chk(input string req, input logic [15:0] act, input logic [15:0] exp);
      n_chk++;
      if (act !== exp) begin
         n_bad++;
         $display("FAIL %s: actual %h expected %h", req, act, exp);
      end
   endtask

   task automatic pulse(input logic [1:0] ab, input logic [1:0] ba);
      #1 cap_ab_clk = ab; cap_ba_clk = ba;
      #1 cap_ab_clk = '0; cap_ba_clk = '0;
      #1;
   endtask

   initial begin
      repeat (20000) @(posedge clk);
      if (!done) begin
         n_chk++; n_bad++;
         $display("FAIL watchdog: actual hung expected done");
         $display("%0d/%0d checks passed", n_chk - n_bad, n_chk);
         $finish;
      end
   end

   initial begin
      // R7 reset state: clear both sections, view stored data
      @(negedge clk);
      sync_clr = 1'b1; sel_ab = '1; sel_ba = '1; drv_b_en = '1; drv_a_en_n = '0;
      a_in = 16'hFFFF; b_in = 16'hFFFF;
      pulse(2'b11, 2'b11);
      sync_clr = 1'b0;
      chk("R7 reset b_out", b_out, 16'h0000);
      chk("R7 reset a_out", a_out, 16'h0000);

      // vector walk on section 0, section 1 in live loopback (R1)
      for (int i = 0; i < 7; i++) begin
         @(negedge clk);
         a_in = {8'hE7, VEC[i].a}; b_in = {8'h7E, VEC[i].b};
         sel_ab = {1'b0, VEC[i].sab}; sel_ba = {1'b0, VEC[i].sba};
         drv_b_en = {1'b1, VEC[i].enb}; drv_a_en_n = {1'b0, VEC[i].enan};
         pulse({1'b0, VEC[i].cab}, {1'b0, VEC[i].cba});
         chk("R4/R2/R3/R6 a_out", {8'h00, a_out[7:0]}, {8'h00, VEC[i].ea});
         chk("R4/R2/R3/R6 b_out", {8'h00, b_out[7:0]}, {8'h00, VEC[i].eb});
         chk("R5 a_oe", {15'd0, a_oe[0]}, {15'd0, VEC[i].eaoe});
         chk("R5 b_oe", {15'd0, b_oe[0]}, {15'd0, VEC[i].eboe});
         chk("R1 sec1 b_out", {8'h00, b_out[15:8]}, 16'h00E7);
         chk("R1 sec1 a_out", {8'h00, a_out[15:8]}, 16'h007E);
      end

      // R1: section 1 capture leaves section 0 stored data alone
      @(negedge clk);
      sel_ab = 2'b11; sel_ba = 2'b01; drv_b_en = 2'b11; drv_a_en_n = 2'b00;
      a_in = 16'hD2_44; b_in = 16'h3B_55;
      pulse(2'b10, 2'b00);
      chk("R1 sec1 stored", {8'h00, b_out[15:8]}, 16'h00D2);
      chk("R1 sec0 untouched ab", {8'h00, b_out[7:0]}, 16'h0077);
      chk("R1 sec0 untouched ba", {8'h00, a_out[7:0]}, 16'h000F);

      // R7: clear one register only
      @(negedge clk);
      sync_clr = 1'b1;
      pulse(2'b01, 2'b00);
      sync_clr = 1'b0;
      chk("R7 cleared ab", {8'h00, b_out[7:0]}, 16'h0000);
      chk("R7 ba kept", {8'h00, a_out[7:0]}, 16'h000F);

      // R8: loopback hold on section 0, buses resolved by the bench
      @(negedge clk);
      sel_ab = 2'b10; sel_ba = 2'b00; drv_b_en = 2'b11; drv_a_en_n = 2'b00;
      a_in[7:0] = 8'h4B;
      #1 b_in[7:0] = b_oe[0] ? b_out[7:0] : b_in[7:0];
      #1;
      for (int c = 0; c < 40; c++) begin
         @(negedge clk);
         a_in[7:0] = a_oe[0] ? a_out[7:0] : a_in[7:0];
         #1 b_in[7:0] = b_oe[0] ? b_out[7:0] : b_in[7:0];
         if (c == 20) pulse(2'b01, 2'b01);
         if (c % 10 == 9) begin
            chk("R8 hold bus A", {8'h00, a_in[7:0]}, 16'h004B);
            chk("R8 hold bus B", {8'h00, b_in[7:0]}, 16'h004B);
         end
      end
      // R3: capture during the hold took the held value
      @(negedge clk);
      sel_ab = 2'b01; sel_ba = 2'b01;
      a_in[7:0] = 8'h00; b_in[7:0] = 8'h00;
      #1;
      chk("R3 captured during hold ab", {8'h00, b_out[7:0]}, 16'h004B);
      chk("R3 captured during hold ba", {8'h00, a_out[7:0]}, 16'h004B);

      done = 1'b1;
      $display("%0d/%0d checks passed", n_chk - n_bad, n_chk);
      $finish;
   end
endmodule